// File: doc/BRIEF.md
# Two-Channel Compare-Match Timer

This block holds two independent 16-bit up-counters. Each counter advances on a divided version of a peripheral clock enable. Software sets each channel's modulus through a compare constant. When a running counter sits at its constant and the next prescaled tick arrives, the counter folds back to zero. On that tick the channel can raise a one-cycle interrupt pulse. The same period then repeats for as long as the channel runs.

Software reaches the block through a simple 16-bit register port. Each access is a single cycle with a select, a write flag, a byte address and write data, and read data comes back combinationally in the same cycle. One shared register holds the run bit of each channel. Every channel has three registers of its own: a control word, the live counter and the compare constant. The control word chooses one of four prescale ratios and gates the interrupt.

Top module: `mtu_top`

## Requirements
- R1: Only 16-bit accesses are used, and bit 0 of the byte address is ignored. Offsets are: 0x0 run register; 0x2, 0x4 and 0x6 are the control, counter and constant of channel 0; 0x8, 0xA and 0xC are the same three registers of channel 1.
- R2: Bit n of the run register starts channel n when 1 and stops it when 0. Reading the run register returns both run bits in bits [1:0] and zeros above them. A channel emits no interrupt unless it was running in the previous cycle.
- R3: Control bits [1:0] hold the prescale select s. A running counter advances once per 8 << (2*s) enabled input cycles, which gives 8, 32, 128 or 512.
- R4: A read of a control register returns bit 7 as 1, bit 6 as the interrupt enable and bits [1:0] as the prescale select. All other bits read 0, whatever value was written to them.
- R5: With the interrupt enable set, each compare match drives that channel's irq output high for exactly one clock cycle. With the enable clear, no pulse is produced.
- R6: A prescaled tick that finds the counter equal to its constant returns the counter to 0 and counts as a compare match. The interrupt period is therefore (constant+1) prescaled ticks.
- R7: After reset both constants read 0xFFFF, both counters and the run register read 0, both control registers read 0x0080, and both irq outputs are low.
- R8: A write to a counter register takes effect at the clock edge of the write, whether the channel is running or stopped.
- R9: While a channel's run bit is 0, its counter keeps its value except when software writes it.
- R10: The prescale phase restarts when a channel is started. Only cycles with tick_en high advance the prescaler.
- R11: Offset 0xE is unmapped: reads return 0 and writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Peripheral clock enable that the prescalers count |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of a read, 0 otherwise |
| irq | output | 2 | One-cycle compare-match pulse per channel |

## Verification
A prescaler phase that is corrupted or not restarted shows up at the ports as a first interrupt that lands early or late. The error is visible on the first pulse after a start, which comes (constant+1) times the prescale ratio cycles later. A bench that measures that distance to the cycle therefore catches it within one period. A counter that drifts while stopped, or a wrong wrap point, changes the readback value, the gap between pulses, or both, by the next match. Errors in control readback or address decoding show up on the very first read of the affected offset.

// File: rtl/mtu_pkg.sv
package mtu_pkg;
  localparam int CH_N   = 2;
  localparam int DW     = 16;
  localparam int AW     = 4;
  localparam int SEL_W  = 2;
  localparam int IDX_W  = AW - 1;
  localparam int REGS_PER_CH = 3;
  // widest divider is 8 << (2*(2^SEL_W-1)); counter holds divider-1
  localparam int PSC_W  = 3 + 2 * ((1 << SEL_W) - 1);
  localparam logic [IDX_W-1:0] IDX_RUN = '0;

  function automatic logic [IDX_W-1:0] ctrl_idx(input int ch);
    return IDX_W'(1 + REGS_PER_CH * ch);
  endfunction
  function automatic logic [IDX_W-1:0] cnt_idx(input int ch);
    return IDX_W'(2 + REGS_PER_CH * ch);
  endfunction
  function automatic logic [IDX_W-1:0] cst_idx(input int ch);
    return IDX_W'(3 + REGS_PER_CH * ch);
  endfunction
endpackage

// File: rtl/mtu_prescale.sv
module mtu_prescale
  import mtu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick_en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PSC_W-1:0] psc_q, psc_d;
  logic [PSC_W:0]   span;
  logic [PSC_W-1:0] lim;
  logic             hit;

  always_comb begin
    span = (PSC_W+1)'(8) << (2 * sel);
    lim  = PSC_W'(span - 1'b1);
    hit  = (psc_q >= lim);
    tick = run & tick_en & hit;
    if (!run)         psc_d = '0;
    else if (tick_en) psc_d = hit ? '0 : psc_q + 1'b1;
    else              psc_d = psc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psc_q <= '0;
    else        psc_q <= psc_d;
  end
endmodule

// File: rtl/mtu_channel.sv
module mtu_channel
  import mtu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick_en,
  input  logic          we_ctrl,
  input  logic          we_cnt,
  input  logic          we_cst,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl_rd,
  output logic [DW-1:0] cnt,
  output logic [DW-1:0] cst,
  output logic          irq
);
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             ie_q, ie_d;
  logic [DW-1:0]    cnt_q, cnt_d;
  logic [DW-1:0]    cst_q, cst_d;
  logic             irq_q, irq_d;
  logic             tick, match;

  mtu_prescale u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .tick_en (tick_en),
    .sel     (sel_q),
    .tick    (tick)
  );

  always_comb begin
    match = tick & (cnt_q == cst_q);
    sel_d = we_ctrl ? wdata[SEL_W-1:0] : sel_q;
    ie_d  = we_ctrl ? wdata[6] : ie_q;
    cst_d = we_cst ? wdata : cst_q;
    if (we_cnt)     cnt_d = wdata;
    else if (match) cnt_d = '0;
    else if (tick)  cnt_d = cnt_q + 1'b1;
    else            cnt_d = cnt_q;
    irq_d = match & ie_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      ie_q  <= 1'b0;
      cnt_q <= '0;
      cst_q <= '1;
      irq_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      ie_q  <= ie_d;
      cnt_q <= cnt_d;
      cst_q <= cst_d;
      irq_q <= irq_d;
    end
  end

  assign ctrl_rd = DW'({1'b1, ie_q, 4'b0000, sel_q});
  assign cnt     = cnt_q;
  assign cst     = cst_q;
  assign irq     = irq_q;
endmodule

// File: rtl/mtu_top.sv
module mtu_top
  import mtu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [CH_N-1:0] irq
);
  logic [1:0]            rst_sync;
  logic                  rst_s_n;
  logic [CH_N-1:0]       run_q, run_d;
  logic [IDX_W-1:0]      idx;
  logic                  wr;
  logic [CH_N-1:0][DW-1:0] ctrl_vec, cnt_vec, cst_vec;
  logic [DW-1:0]         rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  assign idx = bus_addr[AW-1:1];
  assign wr  = bus_sel & bus_we;

  always_comb begin
    run_d = (wr && idx == IDX_RUN) ? bus_wdata[CH_N-1:0] : run_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) run_q <= '0;
    else          run_q <= run_d;
  end

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    mtu_channel u_ch (
      .clk     (clk),
      .rst_n   (rst_s_n),
      .run     (run_q[c]),
      .tick_en (tick_en),
      .we_ctrl (wr && idx == ctrl_idx(c)),
      .we_cnt  (wr && idx == cnt_idx(c)),
      .we_cst  (wr && idx == cst_idx(c)),
      .wdata   (bus_wdata),
      .ctrl_rd (ctrl_vec[c]),
      .cnt     (cnt_vec[c]),
      .cst     (cst_vec[c]),
      .irq     (irq[c])
    );
  end

  always_comb begin
    rd = '0;
    if (idx == IDX_RUN) rd = DW'(run_q);
    for (int c = 0; c < CH_N; c++) begin
      if (idx == ctrl_idx(c)) rd = ctrl_vec[c];
      if (idx == cnt_idx(c))  rd = cnt_vec[c];
      if (idx == cst_idx(c))  rd = cst_vec[c];
    end
    bus_rdata = (bus_sel && !bus_we) ? rd : '0;
  end
endmodule

// File: rtl/mtu_checker.sv
module mtu_checker
  import mtu_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            bus_sel,
  input logic            bus_we,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_rdata,
  input logic [CH_N-1:0] irq,
  input logic [CH_N-1:0] run_q,
  input logic [CH_N-1:0][DW-1:0] cnt_vec,
  input logic [CH_N-1:0][DW-1:0] cst_vec
);
  for (genvar c = 0; c < CH_N; c++) begin : g_chk
    logic cnt_wr;
    logic ctrl_rd;
    assign cnt_wr  = bus_sel & bus_we & (bus_addr[AW-1:1] == IDX_W'(2 + 3 * c));
    assign ctrl_rd = bus_sel & ~bus_we & (bus_addr[AW-1:1] == IDX_W'(1 + 3 * c));

    assert_irq_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq[c] |=> !irq[c]);

    assert_irq_needs_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
      irq[c] |-> $past(run_q[c]));

    assert_match_on_const_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq[c] |-> ($past(cnt_vec[c]) == $past(cst_vec[c])));

    assert_hold_when_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q[c] && !cnt_wr) |=> (cnt_vec[c] == $past(cnt_vec[c])));

    assert_ctrl_readback_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_rd |-> (bus_rdata[7] && bus_rdata[15:8] == 8'h00 && bus_rdata[5:2] == 4'h0));
  end
endmodule

bind mtu_top mtu_checker i_mtu_checker (
  .clk       (clk),
  .rst_n     (rst_s_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .run_q     (run_q),
  .cnt_vec   (cnt_vec),
  .cst_vec   (cst_vec)
);

// File: tb/test_mtu_top.sv
module test_mtu_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  irq;

  int total = 0;
  int bad = 0;
  bit half_rate = 0;
  bit done = 0;
  int irq0_seen = 0;

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t sb_q[$];

  mtu_top i_mtu_top (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  initial forever begin
    @(negedge clk);
    tick_en = half_rate ? ~tick_en : 1'b1;
    if (irq[0]) irq0_seen++;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data and compares with the port
  initial forever begin
    @(negedge clk);
    #(CLK_P/4);
    if (bus_sel && !bus_we) begin
      if (sb_q.size() == 0) chk("scoreboard empty", 1, 0);
      else begin
        item_t it;
        it = sb_q.pop_front();
        chk(it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic bus_write(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic bus_read(logic [3:0] a, logic [15:0] exp, string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    @(negedge clk);
    sb_q.push_back(it);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic wait_irq(int c, int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!irq[c] && n < limit);
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    int seen;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R7 reset state, R1 map
    chk("R7 irq low after reset", irq, 2'b00);
    bus_read(4'h0, 16'h0000, "R7 run reg reset");
    bus_read(4'h2, 16'h0080, "R7 ctrl0 reset");
    bus_read(4'h4, 16'h0000, "R7 cnt0 reset");
    bus_read(4'h6, 16'hFFFF, "R7 cst0 reset");
    bus_read(4'h8, 16'h0080, "R7 ctrl1 reset");
    bus_read(4'hA, 16'h0000, "R7 cnt1 reset");
    bus_read(4'hC, 16'hFFFF, "R7 cst1 reset");

    // R4 control readback masking
    bus_write(4'h2, 16'hFFFF);
    bus_read(4'h2, 16'h00C3, "R4 ctrl0 all ones");
    bus_write(4'h2, 16'h0040);
    bus_read(4'h2, 16'h00C0, "R4 ctrl0 ie only");

    // R11 unmapped offset
    bus_write(4'hE, 16'hFFFF);
    bus_read(4'hE, 16'h0000, "R11 unmapped read");
    bus_read(4'h6, 16'hFFFF, "R11 cst0 untouched");
    bus_read(4'hC, 16'hFFFF, "R11 cst1 untouched");
    bus_read(4'h0, 16'h0000, "R11 run untouched");

    // R3/R6/R10: sel 0, constant 2 -> first pulse 24 cycles after start
    bus_write(4'h6, 16'h0002);
    bus_read(4'h6, 16'h0002, "R1 cst0 readback");
    bus_write(4'h0, 16'h0001);
    wait_irq(0, 1000, n);
    chk("R10 first irq0 after start", n, 24);
    @(negedge clk);
    chk("R5 irq0 single cycle", irq[0], 1'b0);
    wait_irq(0, 1000, n);
    chk("R6 irq0 period (c+1)*8", n + 1, 24);
    bus_read(4'h0, 16'h0001, "R2 run readback");

    // R9/R8 stop, write, hold
    bus_write(4'h0, 16'h0000);
    bus_write(4'h4, 16'h1234);
    bus_read(4'h4, 16'h1234, "R8 cnt0 write stopped");
    seen = irq0_seen;
    idle(60);
    bus_read(4'h4, 16'h1234, "R9 cnt0 held while stopped");
    chk("R2 no irq0 while stopped", irq0_seen - seen, 0);

    // R3 sel 2 on channel 1, constant 0
    bus_write(4'h8, 16'h0042);
    bus_write(4'hC, 16'h0000);
    seen = irq0_seen;
    bus_write(4'h0, 16'h0002);
    wait_irq(1, 2000, n);
    chk("R3 irq1 first at 128", n, 128);
    @(negedge clk);
    chk("R5 irq1 single cycle", irq[1], 1'b0);
    wait_irq(1, 2000, n);
    chk("R3 irq1 period 128", n + 1, 128);
    chk("R2 channel0 idle while ch1 runs", irq0_seen - seen, 0);

    // R5 enable clear: no pulse; R6 counter wraps at constant 0
    bus_write(4'h8, 16'h0001);
    wait_irq(1, 300, n);
    chk("R5 no irq1 with enable clear", irq[1], 1'b0);
    bus_read(4'hA, 16'h0000, "R6 cnt1 stays at 0 with const 0");

    // R3 sel 3 on channel 0, constant 1 -> 1024
    bus_write(4'h0, 16'h0000);
    bus_write(4'h2, 16'h0043);
    bus_write(4'h6, 16'h0001);
    bus_write(4'h4, 16'h0000);
    bus_write(4'h0, 16'h0001);
    wait_irq(0, 3000, n);
    chk("R3 irq0 sel3 at 1024", n, 1024);

    // R10 half-rate enable doubles the period: sel 0, const 3 -> 64
    bus_write(4'h0, 16'h0000);
    bus_write(4'h2, 16'h0040);
    bus_write(4'h6, 16'h0003);
    bus_write(4'h4, 16'h0000);
    half_rate = 1;
    bus_write(4'h0, 16'h0001);
    wait_irq(0, 1000, n);
    @(negedge clk);
    wait_irq(0, 1000, n);
    chk("R10 half-rate period 64", n + 1, 64);
    half_rate = 0;

    // R8 write while running
    bus_write(4'h0, 16'h0000);
    bus_write(4'h2, 16'h0043);
    bus_write(4'h6, 16'h00FF);
    bus_write(4'h4, 16'h0000);
    bus_write(4'h0, 16'h0001);
    bus_write(4'h4, 16'h0042);
    bus_read(4'h4, 16'h0042, "R8 cnt0 write while running");

    idle(3);
    chk("scoreboard drained", sb_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule